// File: doc/BRIEF.md
# Two-Port Address Contention Arbiter

This block sits beside a true two-port memory and settles the case where both ports reach for the same word at the same moment. Each side presents an enable, a word address and a write strobe. When both sides are enabled on equal addresses, one side keeps the word and the other is told it is busy. The port that reached the address first wins. When both arrive in the same cycle, the left port wins. The grant lasts until the winner leaves the word.

A static mode strap chooses between two roles. As master, the block runs its own arbitration and drives registered, active-low busy outputs. Those outputs can be wired to further devices that hold extra data bits of the same word. As slave, the block takes the busy decision from a master through its busy inputs, and its own busy outputs stay inactive. In both roles it produces qualified write enables, which the memory array uses in place of the raw strobes, so that a busy port cannot change the contended word. All pins are plain control signals and there is no back-pressure.

Top module: `contention_arbiter`

## Requirements
- R1: Contention exists only when both enables are high and the two addresses are equal. In any cycle without it, both busy outputs are high after the next rising edge.
- R2: A port is "arriving" in a cycle when its enable is high and, at the previous rising edge, its enable was low or its address was different. The write strobe plays no part in this. When a match starts with exactly one arriving port, the port that was already there wins and the arriving port is the loser.
- R3: The busy outputs are active-low and registered. Each shows the decision made from the inputs at the preceding rising edge. Both are high during reset and after reset.
- R4: With `master_mode` low (slave), both busy outputs are held high. Each write enable is then gated only by its own active-low busy input.
- R5: A qualified write enable is high only when that port's enable and strobe are both high and the port is not the loser. In master mode the loser is decided in the same cycle, before busy is registered.
- R6: When both ports arrive in the same cycle on a match, the left port wins.
- R7: A grant is held while the match lasts and the winner does not arrive again. When the winner leaves, busy to the loser goes high after the next edge.
- R8: The two busy outputs are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | 1 = master (drives busy), 0 = slave (takes busy) |
| l_en | input | 1 | Left port enable |
| l_addr | input | ADDR_W | Left port word address |
| l_wr | input | 1 | Left port write strobe |
| r_en | input | 1 | Right port enable |
| r_addr | input | ADDR_W | Right port word address |
| r_wr | input | 1 | Right port write strobe |
| busy_l_in_n | input | 1 | Slave mode: busy to left, active low |
| busy_r_in_n | input | 1 | Slave mode: busy to right, active low |
| busy_l_n | output | 1 | Busy to left, active low, registered |
| busy_r_n | output | 1 | Busy to right, active low, registered |
| l_wr_ok | output | 1 | Qualified left write enable |
| r_wr_ok | output | 1 | Qualified right write enable |

## Verification
The qualified write enables respond in the same cycle as the inputs that drive them. The busy outputs respond one rising edge later. Each input vector is driven at a falling edge and queued with both expectations. The monitor samples the write enables 1 ns after that falling edge, before the register can change, and samples busy 1 ns after the next rising edge. Hold, release and slave-mode vectors are sequenced so that every expected busy value follows from the vector just before it.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    GNT_NONE  = 2'd0,
    GNT_LEFT  = 2'd1,
    GNT_RIGHT = 2'd2
  } gnt_e;
endpackage

// File: rtl/port_tracker.sv
// Remembers a port's enable and address from the last edge and flags
// when the port has just arrived on its current address.
module port_tracker #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              fresh
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  assign fresh = en && (!en_q || (addr_q != addr));
endmodule

// File: rtl/contention_core.sv
// Grant state machine: decides the owner of a contended word.
module contention_core #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_fresh,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_fresh,
  output arb_pkg::gnt_e     gnt_q,
  output arb_pkg::gnt_e     gnt_nxt
);
  import arb_pkg::*;

  logic match;
  logic winner_moved;

  assign match = l_en && r_en && (l_addr == r_addr);

  always_comb begin
    winner_moved = 1'b0;
    case (gnt_q)
      GNT_LEFT:  winner_moved = l_fresh;
      GNT_RIGHT: winner_moved = r_fresh;
      default:   winner_moved = 1'b1;
    endcase
  end

  always_comb begin
    gnt_nxt = gnt_q;
    if (!match) begin
      gnt_nxt = GNT_NONE;
    end else if (winner_moved) begin
      // whoever was already on the word keeps it; ties go left
      if (r_fresh && !l_fresh) gnt_nxt = GNT_LEFT;
      else if (l_fresh && !r_fresh) gnt_nxt = GNT_RIGHT;
      else gnt_nxt = GNT_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= GNT_NONE;
    else        gnt_q <= gnt_nxt;
  end
endmodule

// File: rtl/write_gate.sv
// Turns raw write strobes into qualified write enables.
module write_gate (
  input  logic          master_mode,
  input  arb_pkg::gnt_e gnt_nxt,
  input  logic          busy_l_in_n,
  input  logic          busy_r_in_n,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic          r_en,
  input  logic          r_wr,
  output logic          l_wr_ok,
  output logic          r_wr_ok
);
  import arb_pkg::*;

  logic l_block;
  logic r_block;

  always_comb begin
    if (master_mode) begin
      l_block = (gnt_nxt == GNT_RIGHT);
      r_block = (gnt_nxt == GNT_LEFT);
    end else begin
      l_block = !busy_l_in_n;
      r_block = !busy_r_in_n;
    end
  end

  assign l_wr_ok = l_en && l_wr && !l_block;
  assign r_wr_ok = r_en && r_wr && !r_block;
endmodule

// File: rtl/contention_arbiter.sv
module contention_arbiter #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              busy_l_in_n,
  input  logic              busy_r_in_n,
  output logic              busy_l_n,
  output logic              busy_r_n,
  output logic              l_wr_ok,
  output logic              r_wr_ok
);
  import arb_pkg::*;

  logic l_fresh;
  logic r_fresh;
  gnt_e gnt_q;
  gnt_e gnt_nxt;

  port_tracker #(.ADDR_W(ADDR_W)) u_trk_l (
    .clk(clk), .rst_n(rst_n), .en(l_en), .addr(l_addr), .fresh(l_fresh)
  );

  port_tracker #(.ADDR_W(ADDR_W)) u_trk_r (
    .clk(clk), .rst_n(rst_n), .en(r_en), .addr(r_addr), .fresh(r_fresh)
  );

  contention_core #(.ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_addr(l_addr), .l_fresh(l_fresh),
    .r_en(r_en), .r_addr(r_addr), .r_fresh(r_fresh),
    .gnt_q(gnt_q), .gnt_nxt(gnt_nxt)
  );

  write_gate u_gate (
    .master_mode(master_mode), .gnt_nxt(gnt_nxt),
    .busy_l_in_n(busy_l_in_n), .busy_r_in_n(busy_r_in_n),
    .l_en(l_en), .l_wr(l_wr), .r_en(r_en), .r_wr(r_wr),
    .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
  );

  // the registered grant drives busy; the mode strap only masks it
  assign busy_l_n = !(master_mode && (gnt_q == GNT_RIGHT));
  assign busy_r_n = !(master_mode && (gnt_q == GNT_LEFT));
endmodule

// File: rtl/contention_arbiter_chk.sv
module contention_arbiter_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              l_en,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_wr,
  input logic              r_en,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_wr,
  input logic              busy_l_in_n,
  input logic              busy_r_in_n,
  input logic              busy_l_n,
  input logic              busy_r_n,
  input logic              l_wr_ok,
  input logic              r_wr_ok
);
  logic same_word;
  assign same_word = l_en && r_en && (l_addr == r_addr);

  assert_single_loser_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_l_n || busy_r_n);

  assert_release_no_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !same_word |=> (busy_l_n && busy_r_n));

  assert_slave_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (busy_l_n && busy_r_n));

  assert_slave_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && (!busy_l_in_n || !busy_r_in_n)) |->
      ((busy_l_in_n || !l_wr_ok) && (busy_r_in_n || !r_wr_ok)));

  assert_wr_needs_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_wr_ok || (l_en && l_wr)) && (!r_wr_ok || (r_en && r_wr)));

  assert_loser_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !busy_r_n && same_word && $stable(l_en) && $stable(l_addr))
      |-> !r_wr_ok);

  assert_grant_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !busy_r_n && same_word && $stable(l_en) && $stable(l_addr))
      |=> (!master_mode || !busy_r_n));
endmodule

bind contention_arbiter contention_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/contention_arbiter_test.sv
`timescale 1ns/1ps
module contention_arbiter_test;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_en = 1'b0, l_wr = 1'b0, r_en = 1'b0, r_wr = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic busy_l_in_n = 1'b1, busy_r_in_n = 1'b1;
  logic busy_l_n, busy_r_n, l_wr_ok, r_wr_ok;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic  lok, rok, bl, br;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  contention_arbiter #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
    .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
    .busy_l_in_n(busy_l_in_n), .busy_r_in_n(busy_r_in_n),
    .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
    .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
  );

  task automatic drive(input logic m, input logic le, input int la, input logic lw,
                       input logic re, input int ra, input logic rw,
                       input logic bli, input logic bri,
                       input logic elok, input logic erok,
                       input logic ebl, input logic ebr, input string tag);
    exp_t e;
    @(negedge clk);
    master_mode = m; l_en = le; l_addr = AW'(la); l_wr = lw;
    r_en = re; r_addr = AW'(ra); r_wr = rw;
    busy_l_in_n = bli; busy_r_in_n = bri;
    e.lok = elok; e.rok = erok; e.bl = ebl; e.br = ebr; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: write enables in the same cycle, busy after the next edge
  initial begin
    forever begin
      exp_t e;
      logic lok_s, rok_s;
      @(negedge clk);
      #1;
      if (sb.size() != 0) begin
        e = sb.pop_front();
        lok_s = l_wr_ok; rok_s = r_wr_ok;
        checks++;
        if (lok_s !== e.lok || rok_s !== e.rok) begin
          fails++;
          $display("FAIL %s wr_ok: got l=%b r=%b expected l=%b r=%b",
                   e.tag, lok_s, rok_s, e.lok, e.rok);
        end
        @(posedge clk);
        #1;
        checks++;
        if (busy_l_n !== e.bl || busy_r_n !== e.br) begin
          fails++;
          $display("FAIL %s busy: got l=%b r=%b expected l=%b r=%b",
                   e.tag, busy_l_n, busy_r_n, e.bl, e.br);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (busy_l_n !== 1'b1 || busy_r_n !== 1'b1) begin
      fails++;
      $display("FAIL R3 reset: got l=%b r=%b expected l=1 r=1", busy_l_n, busy_r_n);
    end
    rst_n = 1'b1;

    // m  le la lw  re ra rw  bli bri  lok rok bl br
    drive(1, 1, 5, 0, 0, 0, 0, 1, 1, 0, 0, 1, 1, "R1 single port");
    drive(1, 1, 5, 0, 1, 5, 1, 1, 1, 0, 0, 1, 0, "R2 right arrives late");
    drive(1, 1, 5, 0, 1, 5, 1, 1, 1, 0, 0, 1, 0, "R7 hold");
    drive(1, 1, 5, 1, 1, 5, 1, 1, 1, 1, 0, 1, 0, "R5 winner writes");
    drive(1, 1, 6, 0, 1, 5, 1, 1, 1, 0, 1, 1, 1, "R7 winner leaves");
    drive(1, 1, 5, 1, 1, 5, 1, 1, 1, 0, 1, 0, 1, "R2 left arrives late");
    drive(1, 1, 5, 1, 0, 5, 0, 1, 1, 1, 0, 1, 1, "R7 right drops enable");
    drive(1, 0, 5, 1, 0, 5, 1, 1, 1, 0, 0, 1, 1, "R5 strobe without enable");
    drive(1, 1, 9, 1, 1, 9, 1, 1, 1, 1, 0, 1, 0, "R6 same cycle tie");
    drive(1, 1, 10, 1, 1, 10, 1, 1, 1, 1, 0, 1, 0, "R6 both move together");
    drive(1, 0, 7, 1, 1, 7, 1, 1, 1, 0, 1, 1, 1, "R1 left disabled");
    drive(1, 1, 7, 1, 1, 7, 1, 1, 1, 0, 1, 0, 1, "R2 enable rises on match");
    drive(1, 1, 8, 1, 1, 7, 1, 1, 1, 1, 1, 1, 1, "R1 different words");
    drive(0, 1, 1, 1, 1, 2, 1, 0, 1, 0, 1, 1, 1, "R4 slave left busy in");
    drive(0, 1, 4, 1, 1, 4, 1, 1, 0, 1, 0, 1, 1, "R4 slave right busy in");
    drive(0, 1, 4, 1, 1, 4, 1, 1, 1, 1, 1, 1, 1, "R4 slave ignores match");
    drive(1, 0, 4, 0, 0, 4, 0, 1, 1, 0, 0, 1, 1, "R8 idle master");
    drive(1, 1, 3, 0, 1, 3, 0, 1, 1, 0, 0, 1, 0, "R8 tie again");

    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule